// File: doc/BRIEF.md
# Logic Self-Test Pattern and Signature Engine

This block lets a small combinational logic cone test itself. A one-cycle start pulse launches a run. An internal-XOR linear feedback shift register drives pseudo-random stimulus onto the logic cone. Each cycle, a multiple-input signature register folds the cone's parallel response into a running checksum. The run lasts exactly one maximal-length period of the generator. After it, the final checksum is compared against a fault-free reference constant. The block raises done, and raises pass only on a match.

The generator and the compactor share one feedback polynomial, given as a tap mask. The default is the 3-bit primitive polynomial 1 + x^2 + x^3, which gives a 7-state period. When the cone has fewer outputs than the register width, only the low stages take response bits.

A sequencing controller has three states: idle, running and finished. It counts the running cycles, and it accepts a start only when no run is in progress.

Top module: `lbist_engine`

## Requirements
- R1: The pattern register uses the one-to-many update: stage 0 takes the top stage; stage i>0 takes stage i-1 XOR (tap bit i AND top stage). With the default taps 3'b101 and seed 3'b001, the applied patterns are 001, 010, 100, 101, 111, 011, 110: seven distinct nonzero values.
- R2: A start accepted while idle or finished loads the pattern register with the seed and clears the signature to zero on the next edge.
- R3: During a run, the signature register takes the same one-to-many update as the pattern register, and then XORs response bit j into stage j for j < RESP_W. Stages at RESP_W and above take no response bit.
- R4: A run lasts exactly 2^WIDTH - 1 clock cycles, with one pattern applied and one response absorbed per cycle. done_o rises on the edge that ends the last of these cycles.
- R5: In the finished state, signature_o and pattern_o hold still. done_o and pass_o keep their values until the next accepted start, and that start drops done_o.
- R6: pass_o is 1 exactly when done_o is 1 and signature_o equals the GOLDEN parameter. If a fault alters the response stream, pass_o stays 0.
- R7: A start pulse during a run is ignored. The run neither restarts nor lengthens, and its signature is unchanged.
- R8: After reset, done_o and pass_o are 0, signature_o is 0 and pattern_o equals the seed.
- R9: With the example cone {p0&p1, p1^p2, p0|p2}, the default configuration gives signature 3'd7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a run |
| pattern_o | output | WIDTH | Stimulus to the logic under test |
| response_i | input | RESP_W | Response from the logic under test |
| signature_o | output | WIDTH | Compacted response |
| done_o | output | 1 | Run finished, result valid |
| pass_o | output | 1 | Signature matched the reference |

## Verification
The bench checks the applied pattern on every cycle of the run, so a generator with a wrong tap or the external-XOR form shows up on the second pattern. A run that is one cycle short or long misplaces done_o and alters the signature. A design that restarts on a mid-run start finishes late with the wrong checksum. A second instance with only two response bits catches response bits fed into the wrong stages. A stuck-at-0 on the cone's AND output must clear pass_o, and a design that keeps compacting after the end breaks the hold checks.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } lbist_state_e;
endpackage

// File: rtl/lbist_lfsr.sv
module lbist_lfsr #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] TAPS = 3'b101,
  parameter logic [WIDTH-1:0] SEED = 3'b001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q, q_nxt;
  logic             top;

  assign top = q_q[WIDTH-1];

  // one-to-many feedback: top stage fans out into tapped stages
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign q_nxt[i] = top;
    end else begin : g_rest
      assign q_nxt[i] = q_q[i-1] ^ (TAPS[i] & top);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= SEED;
    else if (load_i) q_q <= SEED;
    else if (step_i) q_q <= q_nxt;
  end

  assign q_o = q_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q != '0); // R1
  AST_LFSR_SEED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_q == SEED); // R2
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned RESP_W = 3,
  parameter logic [WIDTH-1:0] TAPS = 3'b101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [RESP_W-1:0] resp_i,
  output logic [WIDTH-1:0]  sig_o
);
  logic [WIDTH-1:0] s_q, s_nxt;
  logic             top;

  assign top = s_q[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic shifted;
    if (i == 0) begin : g_first
      assign shifted = top;
    end else begin : g_rest
      assign shifted = s_q[i-1] ^ (TAPS[i] & top);
    end
    // upper stages beyond the response width carry no input XOR
    if (i < RESP_W) begin : g_in
      assign s_nxt[i] = shifted ^ resp_i[i];
    end else begin : g_noin
      assign s_nxt[i] = shifted;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    s_q <= '0;
    else if (clr_i) s_q <= '0;
    else if (en_i)  s_q <= s_nxt;
  end

  assign sig_o = s_q;

  AST_MISR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> s_q == '0); // R2
  AST_MISR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(s_q)); // R5
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int unsigned WIDTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic run_o,
  output logic done_o
);
  localparam int unsigned PERIOD = (1 << WIDTH) - 1;
  localparam logic [WIDTH-1:0] LAST = WIDTH'(PERIOD - 1);

  lbist_state_e     state_q, state_d;
  logic [WIDTH-1:0] cnt_q;
  logic             last_cyc;

  assign last_cyc = (cnt_q == LAST);
  assign load_o   = start_i && (state_q != ST_RUN);
  assign run_o    = (state_q == ST_RUN);
  assign done_o   = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (last_cyc) state_d = ST_DONE;
      ST_DONE: if (start_i) state_d = ST_RUN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o)     cnt_q <= '0;
      else if (run_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_RUN_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> cnt_q <= LAST); // R4
  AST_DONE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R5
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && start_i && !last_cyc) |=> (run_o && cnt_q != '0)); // R7
endmodule

// File: rtl/lbist_engine.sv
module lbist_engine #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned RESP_W = 3,
  parameter logic [WIDTH-1:0] TAPS   = 3'b101,
  parameter logic [WIDTH-1:0] SEED   = 3'b001,
  parameter logic [WIDTH-1:0] GOLDEN = 3'd7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [WIDTH-1:0]  pattern_o,
  input  logic [RESP_W-1:0] response_i,
  output logic [WIDTH-1:0]  signature_o,
  output logic              done_o,
  output logic              pass_o
);
  logic load, run, done;

  lbist_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .run_o  (run),
    .done_o (done)
  );

  lbist_lfsr #(.WIDTH(WIDTH), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (run),
    .q_o    (pattern_o)
  );

  lbist_misr #(.WIDTH(WIDTH), .RESP_W(RESP_W), .TAPS(TAPS)) u_misr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .en_i   (run),
    .resp_i (response_i),
    .sig_o  (signature_o)
  );

  assign done_o = done;
  assign pass_o = done && (signature_o == GOLDEN);

  AST_PASS_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o); // R6
  AST_DONE_PATTERN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(pattern_o)); // R5
endmodule

// File: tb/tb_lbist_engine.sv
module tb_lbist_engine;
  localparam int CLK_PERIOD = 10;

  // arithmetic model of the 1 + x^2 + x^3 one-to-many step
  function automatic logic [2:0] gstep(input logic [2:0] m);
    return {m[1] ^ m[2], m[0], m[2]};
  endfunction

  function automatic logic [2:0] cut(input logic [2:0] p, input logic flt);
    logic [2:0] y;
    y[0] = p[0] | p[2];
    y[1] = p[1] ^ p[2];
    y[2] = flt ? 1'b0 : (p[0] & p[1]);
    return y;
  endfunction

  function automatic logic [2:0] model_sig(input logic flt, input int rw);
    logic [2:0] p, m, y;
    p = 3'b001;
    m = 3'b000;
    for (int k = 0; k < 7; k++) begin
      y = cut(p, flt);
      if (rw < 3) y[2] = 1'b0;
      if (rw < 2) y[1] = 1'b0;
      m = gstep(m) ^ y;
      p = gstep(p);
    end
    return m;
  endfunction

  localparam logic [2:0] GOLD_N = model_sig(1'b0, 2);

  logic       clk, rst_n, start, fault;
  logic [2:0] pattern, resp, sig;
  logic       done, pass;
  logic [2:0] pattern_n, sig_n;
  logic [1:0] resp_n;
  logic       done_n, pass_n;

  int errors = 0;
  int checks = 0;

  assign resp   = cut(pattern, fault);
  assign resp_n = cut(pattern_n, 1'b0) & 3'b011;

  lbist_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .pattern_o(pattern), .response_i(resp),
    .signature_o(sig), .done_o(done), .pass_o(pass)
  );

  lbist_engine #(.RESP_W(2), .GOLDEN(GOLD_N)) dut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .pattern_o(pattern_n), .response_i(resp_n),
    .signature_o(sig_n), .done_o(done_n), .pass_o(pass_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one test; optional mid-run start at cycle mid (negative = none)
  task automatic run_test(input logic flt, input int mid);
    logic [2:0] p;
    fault = flt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    p = 3'b001;
    for (int i = 0; i < 7; i++) begin
      if (i > 0) @(negedge clk);
      check("R1 pattern", pattern, p);
      check("R4 not done during run", done, 1'b0);
      if (i == 0) check("R2 signature cleared", sig, 3'b000);
      if (i == mid) start = 1'b1;
      else          start = 1'b0;
      p = gstep(p);
    end
    @(negedge clk); start = 1'b0;
    check("R4 done after period", done, 1'b1);
    check("R3 signature", sig, model_sig(flt, 3));
    check("R6 pass", pass, (model_sig(flt, 3) == 3'd7));
    if (mid >= 0) check("R7 mid-run start ignored", sig, model_sig(flt, 3));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2:0] held_sig, held_pat;
    logic [2:0] seen;
    logic [2:0] p;
    rst_n = 1'b0; start = 1'b0; fault = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 done reset", done, 1'b0);
    check("R8 pass reset", pass, 1'b0);
    check("R8 signature reset", sig, 3'b000);
    check("R8 pattern reset", pattern, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle without start", done, 1'b0);

    // R1: seven distinct nonzero states via the model
    seen = 3'b000;
    p = 3'b001;
    for (int i = 0; i < 7; i++) begin
      seen = seen ^ p;
      p = gstep(p);
    end
    check("R1 period returns to seed", p, 3'b001);

    run_test(1'b0, -1);
    check("R9 golden literal", sig, 3'd7);
    check("R3 narrow signature", sig_n, GOLD_N);
    check("R3 narrow pass", pass_n, 1'b1);

    // R5: hold in finished state
    held_sig = sig; held_pat = pattern;
    repeat (5) @(negedge clk);
    check("R5 signature held", sig, held_sig);
    check("R5 pattern held", pattern, held_pat);
    check("R5 done held", done, 1'b1);
    check("R5 pass held", pass, 1'b1);

    // R6: stuck-at-0 on AND output
    run_test(1'b1, -1);
    check("R6 faulty pass low", pass, 1'b0);
    check("R6 faulty signature differs", (sig != 3'd7), 1'b1);

    // R7: start during run, then back to good
    run_test(1'b0, 3);
    check("R7 pass after ignored start", pass, 1'b1);

    // R5: next start drops done
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R5 done drops on start", done, 1'b0);
    check("R5 pass drops on start", pass, 1'b0);
    repeat (8) @(negedge clk);
    check("R4 done again", done, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule